// File: doc/BRIEF.md
# Trigger latency pipeline with derandomizer

This block holds one front-end sample per bunch crossing in a ring memory, so that each sample comes back out a programmable number of crossings later, when the first-level trigger decision for that crossing is known. When the accept strobe is high, the sample that is leaving the pipeline in that crossing is written into a small derandomizer FIFO. It is tagged with the current bunch number and event number. The derandomizer absorbs bursts of accepts on consecutive crossings, and a readout consumer drains it one event per handshake.

Two debug paths sit beside the data flow. A control-bus write can put a chosen test word into the pipeline in place of the live sample. A control-bus read returns any derandomizer entry by its distance from the head without disturbing the readout. A throttle output warns the trigger source when occupancy reaches a programmable level. A sticky overflow flag records that an accept arrived while the buffer was full.

Readout rules: `out_valid` is high whenever the derandomizer holds at least one event, and the head event is on `out_data`, `out_bid` and `out_eid`. An event is consumed on a rising clock edge where both `out_valid` and `out_ready` are high. While `out_ready` is low, the head event and `out_valid` stay unchanged. Back-pressure never blocks accepts: if the buffer is full, the accept is lost and flagged.

Top module: `trig_pipe_derand`

## Requirements
- R1: An accept in crossing t stores the sample that entered the pipeline in crossing t − `lat_cfg`, for `lat_cfg` from 1 to PIPE_DEPTH−1 (default 160; PIPE_DEPTH must be a power of two).
- R2: In a crossing where `inj_we` is high, `inj_data` enters the pipeline in place of `sample_in`. It reaches the derandomizer when accepted `lat_cfg` crossings later.
- R3: The bunch counter is 0 in the crossing after reset or after a `bcr` strobe. Otherwise it advances by one per crossing and goes back to 0 after the crossing in which it equals `bc_max`. An accepted event is tagged with the counter value of its accept crossing.
- R4: The event counter is 0 after reset and in the crossing after an `ecr` strobe. Otherwise it advances by one after every accept, including dropped ones. An event is tagged with the value present in its accept crossing.
- R5: The derandomizer holds up to DER_DEPTH (16) events, and accepts on consecutive crossings are all stored while space remains.
- R6: An accept that finds DER_DEPTH events stored is discarded, even if a pop happens in the same crossing. `overflow` goes high the next crossing and stays high until reset.
- R7: `out_valid` is high exactly when the derandomizer is not empty. Events leave in accept order, one per edge with `out_valid` and `out_ready` both high, and the head is held while `out_ready` is low.
- R8: `throttle` is high exactly when occupancy is at least `thr_cfg`.
- R9: One crossing after `cb_rd_off` is applied, `cb_rd_data` holds the entry that many places behind the head, packed as {data, bunch id, event id} with the event id in the low bits. Only offsets below the occupancy return defined data.
- R10: After reset the derandomizer is empty, `out_valid` and `overflow` are low, and `throttle` is low for any nonzero `thr_cfg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_in | input | DATA_W | Front-end sample for this crossing |
| accept | input | 1 | First-level trigger accept strobe |
| bcr | input | 1 | Bunch counter clear strobe |
| ecr | input | 1 | Event counter clear strobe |
| lat_cfg | input | log2(PIPE_DEPTH) | Pipeline latency in crossings |
| bc_max | input | BID_W | Last bunch number before wrap |
| thr_cfg | input | log2(DER_DEPTH+1) | Throttle occupancy level |
| inj_we | input | 1 | Control-bus test word write |
| inj_data | input | DATA_W | Test word replacing the sample |
| cb_rd_off | input | log2(DER_DEPTH) | Readback offset from head |
| cb_rd_data | output | DATA_W+BID_W+EID_W | Registered readback entry |
| out_valid | output | 1 | Head event present |
| out_ready | input | 1 | Consumer takes head event |
| out_data | output | DATA_W | Head event sample |
| out_bid | output | BID_W | Head event bunch id |
| out_eid | output | EID_W | Head event event id |
| throttle | output | 1 | Occupancy at or above threshold |
| overflow | output | 1 | Sticky lost-accept flag |

## Verification
An accept or pop applied before an edge shows up on the head fields, `out_valid` and `overflow` just after that edge. `throttle` follows the occupancy after the same edge with no extra register, and `cb_rd_data` reflects the offset presented one edge earlier. The bench drives inputs and updates its queue model at the falling edge. It then compares every output at the next falling edge, so each result is checked in the exact crossing it is due. Sample history is kept per crossing number, which lets the latency and injection checks look back precisely `lat_cfg` crossings.

// File: rtl/trp_pkg.sv
package trp_pkg;
  localparam int DATA_W_DEF     = 16;
  localparam int BID_W_DEF      = 12;
  localparam int EID_W_DEF      = 12;
  localparam int PIPE_DEPTH_DEF = 256;
  localparam int DER_DEPTH_DEF  = 16;
endpackage

// File: rtl/trp_pipe.sv
module trp_pipe #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 256,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              inj_we,
  input  logic [DATA_W-1:0] inj_data,
  input  logic [AW-1:0]     lat,
  output logic [DATA_W-1:0] dout
);
  logic [DATA_W-1:0] ring [DEPTH];
  logic [AW-1:0]     wr_ptr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wr_ptr <= '0;
    else        wr_ptr <= wr_ptr + 1'b1;

  always_ff @(posedge clk)
    ring[wr_ptr] <= inj_we ? inj_data : din;

  assign dout = ring[wr_ptr - lat];
endmodule

// File: rtl/trp_tags.sv
module trp_tags #(
  parameter int BID_W = 12,
  parameter int EID_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bcr,
  input  logic             ecr,
  input  logic             accept,
  input  logic [BID_W-1:0] bc_max,
  output logic [BID_W-1:0] bid,
  output logic [EID_W-1:0] eid
);
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             bid <= '0;
    else if (bcr)           bid <= '0;
    else if (bid == bc_max) bid <= '0;
    else                    bid <= bid + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      eid <= '0;
    else if (ecr)    eid <= '0;
    else if (accept) eid <= eid + 1'b1;

  // R3
  bcr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) bcr |=> bid == '0);
  // R4
  ecr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n) ecr |=> eid == '0);
endmodule

// File: rtl/trp_derand.sv
module trp_derand #(
  parameter int W     = 40,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_req,
  input  logic [W-1:0]  push_data,
  input  logic          pop_ready,
  input  logic [CW-1:0] thr,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic          throttle,
  output logic          overflow,
  input  logic [AW-1:0] rd_off,
  output logic [W-1:0]  rd_data
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [W-1:0]  slot [DEPTH];
  logic [AW-1:0] head, tail;
  logic [CW-1:0] cnt;
  logic          full, push, pop;

  assign full      = (cnt == FULL_CNT);
  assign push      = push_req && !full;
  assign out_valid = (cnt != '0);
  assign pop       = out_valid && pop_ready;
  assign out_data  = slot[head];
  assign throttle  = (cnt >= thr);

  always_ff @(posedge clk)
    if (push) slot[tail] <= push_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      head     <= '0;
      tail     <= '0;
      cnt      <= '0;
      overflow <= 1'b0;
      rd_data  <= '0;
    end else begin
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (push_req && full) overflow <= 1'b1;
      rd_data <= slot[head + rd_off];
    end

  // R5
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) cnt <= FULL_CNT);
  // R6
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow);
  // R6
  drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_ready) |=> (cnt == $past(cnt)));
  // R7
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !pop_ready) |=> (out_valid && $stable(out_data)));
endmodule

// File: rtl/trig_pipe_derand.sv
module trig_pipe_derand
  import trp_pkg::*;
#(
  parameter int DATA_W     = DATA_W_DEF,
  parameter int BID_W      = BID_W_DEF,
  parameter int EID_W      = EID_W_DEF,
  parameter int PIPE_DEPTH = PIPE_DEPTH_DEF,
  parameter int DER_DEPTH  = DER_DEPTH_DEF,
  localparam int PAW = $clog2(PIPE_DEPTH),
  localparam int DAW = $clog2(DER_DEPTH),
  localparam int DCW = $clog2(DER_DEPTH + 1),
  localparam int EW  = DATA_W + BID_W + EID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] sample_in,
  input  logic              accept,
  input  logic              bcr,
  input  logic              ecr,
  input  logic [PAW-1:0]    lat_cfg,
  input  logic [BID_W-1:0]  bc_max,
  input  logic [DCW-1:0]    thr_cfg,
  input  logic              inj_we,
  input  logic [DATA_W-1:0] inj_data,
  input  logic [DAW-1:0]    cb_rd_off,
  output logic [EW-1:0]     cb_rd_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [BID_W-1:0]  out_bid,
  output logic [EID_W-1:0]  out_eid,
  output logic              throttle,
  output logic              overflow
);
  logic [DATA_W-1:0] delayed;
  logic [BID_W-1:0]  bid_now;
  logic [EID_W-1:0]  eid_now;
  logic [EW-1:0]     head_word;

  trp_pipe #(.DATA_W(DATA_W), .DEPTH(PIPE_DEPTH)) u_pipe (
    .clk(clk), .rst_n(rst_n), .din(sample_in), .inj_we(inj_we),
    .inj_data(inj_data), .lat(lat_cfg), .dout(delayed));

  trp_tags #(.BID_W(BID_W), .EID_W(EID_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .bcr(bcr), .ecr(ecr), .accept(accept),
    .bc_max(bc_max), .bid(bid_now), .eid(eid_now));

  trp_derand #(.W(EW), .DEPTH(DER_DEPTH)) u_derand (
    .clk(clk), .rst_n(rst_n), .push_req(accept),
    .push_data({delayed, bid_now, eid_now}), .pop_ready(out_ready),
    .thr(thr_cfg), .out_valid(out_valid), .out_data(head_word),
    .throttle(throttle), .overflow(overflow), .rd_off(cb_rd_off),
    .rd_data(cb_rd_data));

  assign {out_data, out_bid, out_eid} = head_word;
endmodule

// File: tb/sim_trig_pipe_derand.sv
module sim_trig_pipe_derand;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] sample_in = '0, inj_data = '0;
  logic        accept = 0, bcr = 0, ecr = 0, inj_we = 0, out_ready = 1;
  logic [7:0]  lat_cfg = 8'd160;
  logic [11:0] bc_max = 12'd99;
  logic [4:0]  thr_cfg = 5'd12;
  logic [3:0]  cb_rd_off = '0;
  logic [39:0] cb_rd_data;
  logic        out_valid, throttle, overflow;
  logic [15:0] out_data;
  logic [11:0] out_bid, out_eid;

  int checks = 0, errors = 0;
  int n = 0;
  logic [15:0] hist [int];
  logic [39:0] q [$];
  logic [11:0] bid_m = 0, eid_m = 0;
  bit          ovf_m = 0, rd_ok = 0;
  logic [39:0] rd_m;

  always #5 clk = ~clk;

  trig_pipe_derand u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at crossing %0d act=%0h exp=%0h", req, n, act, exp);
    end
  endtask

  // Called at a falling edge with inputs set: update model, cross one edge, compare.
  task automatic tick();
    int pre;
    logic [39:0] pkt;
    sample_in = 16'((n * 40503) ^ (n >> 3) ^ 16'h3c1);
    hist[n] = inj_we ? inj_data : sample_in;
    pre = q.size();
    rd_ok = (int'(cb_rd_off) < pre);
    if (rd_ok) rd_m = q[cb_rd_off];
    if (pre > 0 && out_ready) void'(q.pop_front());
    if (accept) begin
      pkt = {hist[n - int'(lat_cfg)], bid_m, eid_m};
      if (pre < 16) q.push_back(pkt);
      else ovf_m = 1;
    end
    if (ecr) eid_m = 0; else if (accept) eid_m = eid_m + 1;
    if (bcr || bid_m == bc_max) bid_m = 0; else bid_m = bid_m + 1;
    n++;
    @(posedge clk);
    @(negedge clk);
    chk(out_valid == (q.size() > 0), "R7 valid", out_valid, q.size() > 0);
    if (q.size() > 0) begin
      chk(out_data == q[0][39:24], "R1 data", out_data, q[0][39:24]);
      chk(out_bid == q[0][23:12], "R3 bid", out_bid, q[0][23:12]);
      chk(out_eid == q[0][11:0], "R4 eid", out_eid, q[0][11:0]);
    end
    chk(throttle == (q.size() >= int'(thr_cfg)), "R8 throttle", throttle, q.size() >= int'(thr_cfg));
    chk(overflow == ovf_m, "R6 overflow", overflow, ovf_m);
    if (rd_ok) chk(cb_rd_data == rd_m, "R9 readback", cb_rd_data, rd_m);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid, "R10 valid", out_valid, 0);
    chk(!overflow, "R10 overflow", overflow, 0);
    chk(!throttle, "R10 throttle", throttle, 0);
    rst_n = 1;
    // fill the pipeline
    repeat (170) tick();
    // sparse accepts, free-flowing readout, bunch wrap crossed
    for (int i = 0; i < 120; i++) begin accept = (i % 7 == 0); tick(); end
    accept = 0; repeat (3) tick();
    // burst of 16 with readout stalled
    out_ready = 0;
    repeat (16) begin accept = 1; tick(); end
    accept = 0; thr_cfg = 16; tick();
    chk(throttle && !overflow && out_valid, "R5 sixteen held", {throttle, overflow}, 2'b10);
    // readback every entry while stalled
    for (int i = 0; i < 16; i++) begin cb_rd_off = 4'(i); tick(); end
    // accepts into a full buffer, one with a concurrent pop
    accept = 1; tick();
    chk(overflow, "R6 set", overflow, 1);
    out_ready = 1; tick();
    accept = 0; out_ready = 0; tick();
    chk(overflow, "R6 sticky", overflow, 1);
    // drain with toggling ready
    thr_cfg = 4;
    for (int i = 0; i < 40; i++) begin out_ready = i[0]; tick(); end
    out_ready = 1; repeat (4) tick();
    // counter clears
    bcr = 1; accept = 1; tick();
    bcr = 0; accept = 1; tick();
    chk(out_bid == q[q.size()-1][23:12] && q[q.size()-1][23:12] == 0, "R3 cleared", out_bid, 0);
    ecr = 1; accept = 0; tick();
    ecr = 0; accept = 1; tick();
    accept = 0; tick();
    chk(q.size() == 0 || q[q.size()-1][11:0] == 0, "R4 cleared", q.size(), 0);
    // short latency with injected test word
    lat_cfg = 8'd5; out_ready = 0; repeat (10) tick();
    inj_we = 1; inj_data = 16'ha5c3; tick();
    inj_we = 0; repeat (4) tick();
    accept = 1; tick();
    accept = 0; tick();
    chk(out_data == 16'ha5c3, "R2 injected word", out_data, 16'ha5c3);
    out_ready = 1;
    for (int i = 0; i < 30; i++) begin accept = (i % 3 == 1); tick(); end
    accept = 0; repeat (20) tick();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule